// File: doc/BRIEF.md
# Per-Period Aligned Pulse Width Modulator

This block produces one high pulse in every output period. A period is 64 ticks of the block clock, and a strobe marks where each period begins. At each strobe the block captures a 6-bit width code and two placement bits. That setting then drives the whole of the following period. The width can therefore change in every period, and so can the placement: against the start of the period, against its end, or in its middle.

The two extreme codes fix the level for the whole period. Code zero gives a solid low and code 63 gives a solid high. A synchronous force input drives the output high whatever the code is. An asynchronous active-low reset returns the block to its idle state, and it should be held for at least two periods.

Top module: `pwm_aligned`

## Requirements
- R1: While reset is low, the output is low. After reset the staged and active settings are code 0, so the output stays low until a non-zero code has passed through both stages.
- R2: For codes 1 to 62, the output is high for code+1 ticks of the 64-tick period.
- R3: With single_i=1 and trail_i=0, the pulse begins at tick 0 of the period.
- R4: With single_i=1 and trail_i=1, the pulse ends at tick 63 and begins at tick 64-W, where W is the width in ticks.
- R5: With single_i=0, the pulse begins at tick floor((64-W)/2) whatever trail_i is.
- R6: Code 0 gives no high tick in the period and code 63 gives 64 high ticks, under every setting of single_i and trail_i.
- R7: A setting captured at one strobe drives the period that begins at the next strobe. The output is registered, so tick t of a period appears after clock edge t+1, counted from the edge that captured that period's strobe.
- R8: While force_i is high at a clock edge, the output is high after that edge whatever the code.
- R9: Changes on code_i, single_i or trail_i at edges without a strobe have no effect on any period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock, 64 ticks per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Period-start strobe, one clock wide |
| force_i | input | 1 | Synchronous force of the output to high |
| code_i | input | 6 | Width code |
| single_i | input | 1 | 1 selects placement against one edge of the period, 0 selects centring |
| trail_i | input | 1 | When single_i is 1: 1 places the pulse at the end of the period, 0 at its start |
| pwm_o | output | 1 | Registered pulse output |

## Verification
The properties assume that frame_i and force_i are synchronous and free of X. They tie tick positions to the internal counter, not to the strobe spacing. Whole-period meaning, however, holds only when a strobe arrives exactly every 64 clocks. The bench keeps to this by issuing each strobe from a task that runs for exactly 64 clocks, and it changes the setting inputs only at falling edges. Mid-period changes are introduced on purpose, and only on the setting inputs, never on the strobe.

// File: rtl/pwm_aligned.sv
module pwm_aligned #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              force_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              single_i,
  input  logic              trail_i,
  output logic              pwm_o
);

  localparam int TICKS = 1 << CODE_W;
  localparam int WW    = CODE_W + 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'(TICKS / 2 - 1);

  logic [CODE_W-1:0] cnt_q, stg_code_q, act_code_q;
  logic              stg_single_q, stg_trail_q, act_single_q, act_trail_q;
  logic [WW-1:0]     width, gap, start, stop, pos;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      stg_code_q   <= '0;
      stg_single_q <= 1'b0;
      stg_trail_q  <= 1'b0;
      act_code_q   <= '0;
      act_single_q <= 1'b0;
      act_trail_q  <= 1'b0;
    end else if (frame_i) begin
      cnt_q        <= '0;
      stg_code_q   <= code_i;
      stg_single_q <= single_i;
      stg_trail_q  <= trail_i;
      act_code_q   <= stg_code_q;
      act_single_q <= stg_single_q;
      act_trail_q  <= stg_trail_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign width = (act_code_q == '0) ? '0 : {1'b0, act_code_q} + WW'(1);
  assign gap   = WW'(TICKS) - width;
  assign start = act_single_q ? (act_trail_q ? gap : '0) : (gap >> 1);
  assign stop  = start + width;
  assign pos   = {1'b0, cnt_q};
  assign hit   = (pos >= start) && (pos < stop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 1'b0;
    else         pwm_o <= force_i | hit;
  end

  a_r8_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> pwm_o);

  a_r6_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_code_q == '0 && !force_i) |=> !pwm_o);

  a_r6_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&act_code_q) && !force_i) |=> pwm_o);

  a_r7_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (act_code_q == $past(stg_code_q) && cnt_q == '0));

  a_r3_left_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && act_single_q && !act_trail_q && act_code_q != '0 && !force_i) |=> pwm_o);

  a_r4_right_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt_q) && act_single_q && act_trail_q && act_code_q != '0 && !force_i) |=> pwm_o);

  a_r5_center_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MID && !act_single_q && act_code_q != '0 && !force_i) |=> pwm_o);

endmodule

// File: tb/pwm_aligned_test.sv
`timescale 1ns/1ps
module pwm_aligned_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, frame, frc, single, trail, pwm;
  logic [5:0] code;

  pwm_aligned uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .force_i(frc),
    .code_i(code), .single_i(single), .trail_i(trail), .pwm_o(pwm)
  );

  int  n_run = 0, n_fail = 0;
  bit  done = 0;
  bit  ticks [64];
  int  h1_code, h2_code;
  bit  h1_s, h1_t, h1_g, h1_v, h2_s, h2_t, h2_g, h2_v;
  bit  prev_forced;

  task automatic chk(string tag, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_w(int c);
    return (c == 0) ? 0 : c + 1;
  endfunction

  function automatic int exp_s(int c, bit s, bit t);
    int w = exp_w(c);
    if (w == 0) return 64;
    if (s && t) return 64 - w;
    if (s) return 0;
    return (64 - w) / 2;
  endfunction

  task automatic eval_period(int c, bit s, bit t, bit g);
    int cnt = 0, first = 64;
    string tw, tf;
    for (int i = 0; i < 64; i++) begin
      if (ticks[i]) begin
        cnt++;
        if (first == 64) first = i;
      end
    end
    tw = (c == 0 || c == 63) ? "R6" : "R2";
    tf = (c == 0) ? "R6" : (s && t) ? "R4" : s ? "R3" : "R5";
    if (g) begin tw = "R9"; tf = "R9"; end
    chk(tw, cnt, exp_w(c), $sformatf("high ticks code=%0d s=%0b t=%0b", c, s, t));
    chk(tf, first, exp_s(c, s, t), $sformatf("first tick code=%0d s=%0b t=%0b", c, s, t));
  endtask

  task automatic frame_run(int c, bit s, bit t, bit f, bit g);
    code = 6'(c); single = s; trail = t; frc = f; frame = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (k == 0) frame = 1'b0;
      if (g && k == 20) begin code = ~6'(c); single = ~s; trail = ~t; end
      if (k == 0) begin
        ticks[63] = pwm;
        if (h2_v && !f && !prev_forced) eval_period(h2_code, h2_s, h2_t, h2_g);
      end else begin
        ticks[k-1] = pwm;
      end
    end
    h2_code = h1_code; h2_s = h1_s; h2_t = h1_t; h2_g = h1_g; h2_v = h1_v;
    h1_code = c; h1_s = s; h1_t = t; h1_g = g; h1_v = 1'b1;
    prev_forced = f;
  endtask

  task automatic count_early(output int ones);
    ones = 0;
    for (int i = 0; i < 63; i++) ones += ticks[i];
  endtask

  task automatic t_reset();
    int lows = 0;
    rst_n = 1'b0; frame = 1'b0; frc = 1'b0; code = 6'h3F; single = 1'b1; trail = 1'b0;
    for (int k = 0; k < 140; k++) begin
      @(negedge clk);
      frame = (k % 64 == 0);
      if (pwm == 1'b0) lows++;
    end
    chk("R1", lows, 140, "low samples during reset");
    frame = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", int'(pwm), 0, "output after release");
  endtask

  task automatic t_latency();
    int ones;
    frame_run(63, 1, 0, 0, 0);
    count_early(ones);
    chk("R7", ones, 0, "highs in period after first capture");
    frame_run(63, 1, 0, 0, 0);
    count_early(ones);
    chk("R7", ones, 63, "highs one period after capture");
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 64; c++)
        frame_run(c, m[1], m[0], 0, (c == 37));
  endtask

  task automatic t_force();
    int ones = 0;
    frame_run(0, 1, 0, 1, 0);
    for (int i = 0; i < 64; i++) ones += ticks[i];
    chk("R8", ones, 64, "high samples while forced with code 0");
    frame_run(15, 0, 1, 0, 0);
    frame_run(47, 1, 1, 0, 0);
    frame_run(31, 0, 0, 0, 0);
    frame_run(0, 0, 0, 0, 0);
    frame_run(0, 0, 0, 0, 0);
  endtask

  initial begin
    h1_v = 0; h2_v = 0; h1_g = 0; h2_g = 0; prev_forced = 0;
    h1_code = 0; h2_code = 0; h1_s = 0; h1_t = 0; h2_s = 0; h2_t = 0;
    t_reset();
    t_latency();
    t_sweep();
    t_force();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL R7 watchdog: actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule